// File: doc/BRIEF.md
# UART FIFO Controller with Watermarks

This block holds the transmit and receive queues of a serial port and the byte-wide registers that software uses to drive them. Software pushes transmit bytes by writing the data register and pops received bytes by reading it. The transmit shifter drains the transmit queue through a pop strobe. The receive shifter fills the receive queue through a push strobe. Each queue keeps an occupancy count, and that count is compared with a programmable threshold. The results appear as a transmit-request level and a receive-ready level for the status logic.

Each queue can run as a full FIFO or as a single-entry buffer. A parameter register reports the fixed depth of each queue as a 3-bit size code. Flush commands empty either queue at once. Overflow and underflow events are latched as sticky flags. Each flag has its own interrupt enable, and the enabled flags combine into one interrupt line.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Register 0 reads {tx FIFO enable (bit 7), tx size code (bits 6:4), rx FIFO enable (bit 3), rx size code (bits 2:0)}. A code n means 2^(n+1) entries. Only bits 7 and 3 are writable, and both reset to 0. With the default depths of 8 the register reads 0x22 after reset.
- R2: A write to register 7 pushes a byte into the transmit queue while the queue is below its capacity. Register 4 reads the transmit count. Status register 2 bit 7 is 1 when the transmit queue is empty.
- R3: A write to register 7 while the transmit queue is full is discarded, and the count does not change. The write sets the transmit-overflow flag, status bit 1.
- R4: rx_push_i stores rx_data_i while the receive queue is below capacity. A read of register 7 with reg_re_i high returns the oldest byte and removes it. Register 6 reads the receive count. Status bit 6 is 1 when the receive queue is empty.
- R5: A receive push into a full queue is discarded and sets receive-overflow, status bit 2. A pop from an empty receive queue is discarded and sets receive-underflow, status bit 0.
- R6: Status bits 2:0 stay set until 1 is written to that bit of register 2. Writing 0 leaves the bit unchanged.
- R7: Writing 1 to register 1 bit 7 empties the transmit queue, and writing 1 to bit 6 empties the receive queue, in the same clock edge as the write. Both bits read back as 0. A flush leaves the status flags unchanged.
- R8: irq_o is high while any status bit 2:0 is set together with the matching enable in register 1 bits 2:0.
- R9: tx_req_o is high while the transmit count is at or below register 3. rx_rdy_o is high while the receive count is above register 5.
- R10: With its FIFO enable at 0, a queue holds at most one byte, and its watermark is treated as 0.
- R11: tx_data_o shows the oldest transmit byte. tx_pop_i removes that byte. A pop of an empty transmit queue is ignored and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Read strobe; pops the receive queue at address 7 |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| tx_pop_i | input | 1 | Transmit shifter takes the head byte |
| tx_data_o | output | 8 | Transmit head byte |
| tx_avail_o | output | 1 | Transmit queue not empty |
| rx_push_i | input | 1 | Receive shifter delivers a byte |
| rx_data_i | input | 8 | Received byte |
| tx_level_o | output | 8 | Transmit occupancy |
| rx_level_o | output | 8 | Receive occupancy |
| tx_req_o | output | 1 | Transmit count at or below its watermark |
| rx_rdy_o | output | 1 | Receive count above its watermark |
| irq_o | output | 1 | Any enabled sticky flag set |

## Verification
The assertions check several rules on every cycle. Occupancy never exceeds the depth. A flush leaves the count at zero on the next cycle. A rejected push or pop leaves the count unchanged. A sticky flag stays set unless it is cleared, and an overflow event always sets its flag. With FIFO mode off, a queue never holds more than one byte. Other behaviour is shown only by the bench scenarios: the threshold outputs across every pairing of fill level and watermark, first-in-first-out order, the read-back value of each register, and the interrupt combining.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [2:0] {
    A_PARAM = 3'd0,
    A_CTRL  = 3'd1,
    A_STAT  = 3'd2,
    A_TXWM  = 3'd3,
    A_TXCNT = 3'd4,
    A_RXWM  = 3'd5,
    A_RXCNT = 3'd6,
    A_DATA  = 3'd7
  } reg_addr_e;

  localparam int unsigned BIT_TX_EN    = 7;
  localparam int unsigned BIT_RX_EN    = 3;
  localparam int unsigned BIT_TX_FLUSH = 7;
  localparam int unsigned BIT_RX_FLUSH = 6;
  localparam int unsigned BIT_TX_EMPTY = 7;
  localparam int unsigned BIT_RX_EMPTY = 6;
  localparam int unsigned NUM_FLAGS    = 3;  // [2] rx overflow, [1] tx overflow, [0] rx underflow
endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int unsigned DEPTH_LOG2 = 3,
  parameter int unsigned DW         = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  single_i,
  input  logic                  flush_i,
  input  logic                  push_i,
  input  logic [DW-1:0]         push_data_i,
  input  logic                  pop_i,
  output logic [DW-1:0]         head_o,
  output logic [DEPTH_LOG2:0]   count_o,
  output logic                  full_o,
  output logic                  empty_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
  localparam int unsigned CW    = DEPTH_LOG2 + 1;

  logic [DW-1:0]         mem_q [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]         count_q, cap;
  logic                  push_ok, pop_ok;

  assign cap     = single_i ? CW'(1) : CW'(DEPTH);
  assign full_o  = (count_q >= cap);
  assign empty_o = (count_q == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign ovf_o   = push_i & full_o & ~flush_i;
  assign unf_o   = pop_i & empty_o & ~flush_i;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  p_flush_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
  p_full_push_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(count_q));
  p_empty_pop_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !flush_i) |=> (count_q == '0));
  p_single_cap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && count_q <= CW'(1)) |=> (count_q <= CW'(1)));
endmodule

// File: rtl/ufc_regs.sv
module ufc_regs
  import uart_fifo_pkg::*;
#(
  parameter int unsigned TX_LOG2 = 3,
  parameter int unsigned RX_LOG2 = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           reg_addr_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  input  logic [7:0]           tx_count_i,
  input  logic [7:0]           rx_count_i,
  input  logic                 tx_empty_i,
  input  logic                 rx_empty_i,
  input  logic [7:0]           rx_head_i,
  input  logic [NUM_FLAGS-1:0] flag_ev_i,
  output logic                 tx_mode_o,
  output logic                 rx_mode_o,
  output logic                 tx_flush_o,
  output logic                 rx_flush_o,
  output logic                 tx_push_o,
  output logic                 rx_pop_o,
  output logic [7:0]           tx_wm_o,
  output logic [7:0]           rx_wm_o,
  output logic                 irq_o
);
  localparam logic [2:0] TX_CODE = 3'(TX_LOG2 - 1);
  localparam logic [2:0] RX_CODE = 3'(RX_LOG2 - 1);

  reg_addr_e            addr;
  logic                 tx_mode_q, rx_mode_q;
  logic [7:0]           tx_wm_q, rx_wm_q;
  logic [NUM_FLAGS-1:0] en_q, flags_q, clr;

  assign addr       = reg_addr_e'(reg_addr_i);
  assign tx_flush_o = reg_we_i && addr == A_CTRL && reg_wdata_i[BIT_TX_FLUSH];
  assign rx_flush_o = reg_we_i && addr == A_CTRL && reg_wdata_i[BIT_RX_FLUSH];
  assign tx_push_o  = reg_we_i && addr == A_DATA;
  assign rx_pop_o   = reg_re_i && addr == A_DATA;
  assign clr        = (reg_we_i && addr == A_STAT) ? reg_wdata_i[NUM_FLAGS-1:0] : '0;
  assign tx_mode_o  = tx_mode_q;
  assign rx_mode_o  = rx_mode_q;
  assign tx_wm_o    = tx_mode_q ? tx_wm_q : 8'd0;
  assign rx_wm_o    = rx_mode_q ? rx_wm_q : 8'd0;
  assign irq_o      = |(flags_q & en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_mode_q <= 1'b0;
      rx_mode_q <= 1'b0;
      tx_wm_q   <= '0;
      rx_wm_q   <= '0;
      en_q      <= '0;
    end else if (reg_we_i) begin
      case (addr)
        A_PARAM: begin
          tx_mode_q <= reg_wdata_i[BIT_TX_EN];
          rx_mode_q <= reg_wdata_i[BIT_RX_EN];
        end
        A_CTRL:  en_q    <= reg_wdata_i[NUM_FLAGS-1:0];
        A_TXWM:  tx_wm_q <= reg_wdata_i;
        A_RXWM:  rx_wm_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flag_ev_i | (flags_q & ~clr);
  end

  always_comb begin
    case (addr)
      A_PARAM: reg_rdata_o = {tx_mode_q, TX_CODE, rx_mode_q, RX_CODE};
      A_CTRL:  reg_rdata_o = {5'd0, en_q};
      A_STAT:  reg_rdata_o = {tx_empty_i, rx_empty_i, 3'd0, flags_q};
      A_TXWM:  reg_rdata_o = tx_wm_q;
      A_TXCNT: reg_rdata_o = tx_count_i;
      A_RXWM:  reg_rdata_o = rx_wm_q;
      A_RXCNT: reg_rdata_o = rx_count_i;
      default: reg_rdata_o = rx_empty_i ? 8'd0 : rx_head_i;
    endcase
  end

  p_sticky_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_q & ~clr) != '0) |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));
  p_event_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_ev_i != '0) |=> ((flags_q & $past(flag_ev_i)) == $past(flag_ev_i)));
  p_irq_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int unsigned TX_LOG2 = 3,
  parameter int unsigned RX_LOG2 = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] reg_addr_i,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       tx_pop_i,
  output logic [7:0] tx_data_o,
  output logic       tx_avail_o,
  input  logic       rx_push_i,
  input  logic [7:0] rx_data_i,
  output logic [7:0] tx_level_o,
  output logic [7:0] rx_level_o,
  output logic       tx_req_o,
  output logic       rx_rdy_o,
  output logic       irq_o
);
  logic                 tx_mode, rx_mode, tx_flush, rx_flush, tx_push, rx_pop;
  logic                 tx_full, tx_empty, rx_full, rx_empty;
  logic                 tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic [TX_LOG2:0]     tx_cnt;
  logic [RX_LOG2:0]     rx_cnt;
  logic [7:0]           rx_head, tx_wm, rx_wm;
  logic [NUM_FLAGS-1:0] flag_ev;

  ufc_fifo #(.DEPTH_LOG2(TX_LOG2), .DW(8)) i_tx_fifo (
    .clk_i, .rst_ni,
    .single_i(~tx_mode), .flush_i(tx_flush),
    .push_i(tx_push), .push_data_i(reg_wdata_i), .pop_i(tx_pop_i),
    .head_o(tx_data_o), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty),
    .ovf_o(tx_ovf), .unf_o(tx_unf)
  );

  ufc_fifo #(.DEPTH_LOG2(RX_LOG2), .DW(8)) i_rx_fifo (
    .clk_i, .rst_ni,
    .single_i(~rx_mode), .flush_i(rx_flush),
    .push_i(rx_push_i), .push_data_i(rx_data_i), .pop_i(rx_pop),
    .head_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty),
    .ovf_o(rx_ovf), .unf_o(rx_unf)
  );

  assign flag_ev    = {rx_ovf, tx_ovf, rx_unf};  // tx underflow carries no flag
  assign tx_level_o = 8'(tx_cnt);
  assign rx_level_o = 8'(rx_cnt);
  assign tx_avail_o = ~tx_empty;
  assign tx_req_o   = (tx_level_o <= tx_wm);
  assign rx_rdy_o   = (rx_level_o > rx_wm);

  ufc_regs #(.TX_LOG2(TX_LOG2), .RX_LOG2(RX_LOG2)) i_regs (
    .clk_i, .rst_ni,
    .reg_addr_i, .reg_we_i, .reg_re_i, .reg_wdata_i, .reg_rdata_o,
    .tx_count_i(tx_level_o), .rx_count_i(rx_level_o),
    .tx_empty_i(tx_empty), .rx_empty_i(rx_empty), .rx_head_i(rx_head),
    .flag_ev_i(flag_ev),
    .tx_mode_o(tx_mode), .rx_mode_o(rx_mode),
    .tx_flush_o(tx_flush), .rx_flush_o(rx_flush),
    .tx_push_o(tx_push), .rx_pop_o(rx_pop),
    .tx_wm_o(tx_wm), .rx_wm_o(rx_wm), .irq_o
  );

  p_mode_off_txreq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_mode && tx_level_o != 8'd0) |-> !tx_req_o);
  p_mode_off_rxrdy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_mode && rx_level_o != 8'd0) |-> rx_rdy_o);
  p_full_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full |-> tx_avail_o);
  p_unf_no_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_unf |-> (rx_level_o == 8'd0));
  p_tx_unf_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_unf |-> !tx_avail_o);
endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tx_pop = 1'b0;
  logic [7:0] tx_data;
  logic       tx_avail;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] tx_level, rx_level;
  logic       tx_req, rx_rdy, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_avail_o(tx_avail),
    .rx_push_i(rx_push), .rx_data_i(rx_data),
    .tx_level_o(tx_level), .rx_level_o(rx_level),
    .tx_req_o(tx_req), .rx_rdy_o(rx_rdy), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b0;
    #1 d = rdata;
  endtask

  task automatic rx_pop_rd(output logic [7:0] d);
    @(negedge clk); addr = 3'd7; re = 1'b1;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
    #1;
  endtask

  task automatic rx_in(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
    #1;
  endtask

  task automatic tx_out();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset read-back and read-only codes
    rd(3'd0, v); chk("R1 reset param", v, 8'h22);
    rd(3'd2, v); chk("R2 R4 reset status", v, 8'hC0);
    chk("R9 reset tx_req", tx_req, 1);
    chk("R9 reset rx_rdy", rx_rdy, 0);
    chk("R8 reset irq", irq, 0);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R1 modes on, codes read-only", v, 8'hAA);

    // R2 R3 R9 transmit fill sweep against every watermark
    for (int k = 1; k <= 9; k++) begin
      wr(3'd7, 8'((k * 37) & 8'hFF));
      rd(3'd4, v); chk("R2 tx count", v, (k > 8) ? 8 : k);
      for (int w = 0; w <= 8; w++) begin
        wr(3'd3, 8'(w));
        chk("R9 tx_req vs watermark", tx_req, (((k > 8) ? 8 : k) <= w) ? 1 : 0);
      end
    end
    rd(3'd2, v); chk("R3 tx overflow flag", v, 8'h42);
    chk("R8 irq masked", irq, 0);

    // R11 drain in order, 9th byte dropped, empty pop ignored
    for (int k = 1; k <= 8; k++) begin
      chk("R11 tx head order", tx_data, (k * 37) & 8'hFF);
      tx_out();
    end
    chk("R11 tx drained", tx_level, 0);
    chk("R11 tx_avail low", tx_avail, 0);
    tx_out();
    chk("R11 empty pop level", tx_level, 0);
    rd(3'd2, v); chk("R11 no flag on tx empty pop", v, 8'hC2);

    // R8 R6 interrupt and clear
    wr(3'd1, 8'h02); chk("R8 irq enabled", irq, 1);
    wr(3'd2, 8'h00); rd(3'd2, v); chk("R6 zero write keeps flag", v, 8'hC2);
    wr(3'd2, 8'h02); rd(3'd2, v); chk("R6 w1c clears", v, 8'hC0);
    chk("R8 irq drops", irq, 0);
    wr(3'd1, 8'h00);

    // R4 R5 R9 receive fill sweep
    for (int k = 1; k <= 10; k++) begin
      rx_in(8'(8'hA0 + k));
      chk("R4 rx count", rx_level, (k > 8) ? 8 : k);
      for (int w = 0; w <= 8; w++) begin
        wr(3'd5, 8'(w));
        chk("R9 rx_rdy vs watermark", rx_rdy, (((k > 8) ? 8 : k) > w) ? 1 : 0);
      end
    end
    rd(3'd2, v); chk("R5 rx overflow flag", v, 8'h84);
    for (int k = 1; k <= 8; k++) begin
      rx_pop_rd(v); chk("R4 rx order", v, 8'hA0 + k);
    end
    rd(3'd6, v); chk("R4 rx drained", v, 0);
    rx_pop_rd(v);
    rd(3'd6, v); chk("R5 underflow keeps count", v, 0);
    rd(3'd2, v); chk("R5 underflow flag", v, 8'hC5);
    wr(3'd1, 8'h01); chk("R8 irq rx underflow", irq, 1);
    wr(3'd1, 8'h00);

    // R7 flushes keep flags
    wr(3'd7, 8'h11); wr(3'd7, 8'h22); wr(3'd7, 8'h33);
    chk("R7 tx pre-flush", tx_level, 3);
    wr(3'd1, 8'h80);
    chk("R7 tx flushed", tx_level, 0);
    rd(3'd1, v); chk("R7 flush bits read 0", v, 8'h00);
    rd(3'd2, v); chk("R7 flags kept", v, 8'hC5);
    rx_in(8'h55); rx_in(8'h66);
    wr(3'd1, 8'h40);
    chk("R7 rx flushed", rx_level, 0);
    rd(3'd2, v); chk("R7 rx flush flags kept", v, 8'hC5);
    wr(3'd2, 8'h07);

    // R10 single-entry mode, watermarks treated as zero
    wr(3'd0, 8'h00);
    wr(3'd3, 8'd5); wr(3'd5, 8'd5);
    chk("R10 tx_req empty", tx_req, 1);
    wr(3'd7, 8'h77); wr(3'd7, 8'h88);
    rd(3'd4, v); chk("R10 tx capacity one", v, 1);
    rd(3'd2, v); chk("R10 tx overflow at one", v, 8'h42);
    chk("R10 tx_req wm zero", tx_req, 0);
    chk("R10 tx head", tx_data, 8'h77);
    rx_in(8'h99);
    chk("R10 rx_rdy wm zero", rx_rdy, 1);
    rx_in(8'hAA);
    chk("R10 rx capacity one", rx_level, 1);
    rd(3'd2, v); chk("R10 rx overflow at one", v, 8'h06);
    rx_pop_rd(v); chk("R10 rx kept first", v, 8'h99);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule